// File: doc/BRIEF.md
# Hot-Plug Priority Port Selector

This block is the digital control of a switch that routes one display source to one of two sink ports. It watches each port's hot-plug and cable-adapter sense lines and a priority pin. From these it chooses the port to connect, and it drives the single hot-plug and cable-detect lines back to the source. It also drives a port-select and an output-enable signal for the link and auxiliary switches, and reports whether the selected port's auxiliary channel runs differential or I2C-style.

A port change is not made at once. The new selection condition must hold for a settle pause. The selection then flips, and the source's hot-plug line is held low for a long interval so that the source detects the sink again. An active-low sleep pin overrides everything and returns the block to its reset state. Every pin input passes through a two-flop synchroniser. All timing comes from one clock: `PAUSE_CYC`, `SWITCH_CYC` and `MIN_PULSE_CYC` are cycle counts, chosen to fall inside 2 to 4.7 ms, 170 to 400 ms and at least 100 ns.

Top module: `hpd_port_sel`

## Requirements
- R1: While `rst` is high (synchronous, active high), and on the first edge after it, every output is 0, and `sel_b` = 0 (port A).
- R2: Three clock edges after `sleep_n` goes low, `link_en`, `hpd_src`, `cad_src`, `aux_i2c` and `sel_b` are all 0. They stay 0 whatever the other inputs do while `sleep_n` stays low.
- R3: After `sleep_n` rises, `link_en` rises on the third clock edge with `sel_b` = 0 (port A). Selection then restarts from that state, with its timers cleared.
- R4: With both `sense_a` and `sense_b` high, the wanted port is B (`sel_b` = 1) when `prio_b` = 1 and A (`sel_b` = 0) when `prio_b` = 0.
- R5: With exactly one of `sense_a`/`sense_b` high, that port is wanted whatever `prio_b` is. With neither high, `sel_b` keeps its value and `hpd_src` is 0.
- R6: When the wanted port differs from `sel_b`, `sel_b` changes on clock edge `PAUSE_CYC`+3 after the input change. A differing condition that lasts fewer cycles than that causes no change.
- R7: On a port change, `hpd_src` goes low on the edge after `sel_b` changes. It stays low through edge `PAUSE_CYC`+3+`SWITCH_CYC`, and it rises on the next edge if the newly selected port's sense input is high.
- R8: Every high or low level of `hpd_src` lasts at least `MIN_PULSE_CYC` cycles (`MIN_PULSE_CYC` >= 2). A one-cycle high pulse on the selected sense input gives exactly `MIN_PULSE_CYC` high cycles.
- R9: Outside a switch interval, `hpd_src` follows the sense input of the selected port, three clock edges after that input changes.
- R10: `cad_src` follows the cable-adapter input of the selected port (`adapt_a` when `sel_b` = 0, `adapt_b` when 1), three clock edges after that input changes.
- R11: `aux_i2c` is 1 (I2C-style auxiliary mode) when the selected port's cable-adapter input is high, and 0 (differential mode) when it is low. It has the same latency as `cad_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_n | input | 1 | Low-power request, active low |
| sense_a | input | 1 | Port A hot-plug sense |
| sense_b | input | 1 | Port B hot-plug sense |
| adapt_a | input | 1 | Port A cable-adapter sense |
| adapt_b | input | 1 | Port B cable-adapter sense |
| prio_b | input | 1 | 1 favours port B when both are plugged, 0 favours port A |
| hpd_src | output | 1 | Hot-plug line to the source |
| cad_src | output | 1 | Cable-detect line to the source |
| sel_b | output | 1 | Port select: 0 = A, 1 = B |
| link_en | output | 1 | Enable for the link and auxiliary switches |
| aux_i2c | output | 1 | Auxiliary mode: 1 = I2C-style, 0 = differential |

## Verification
The level outputs `hpd_src`, `cad_src` and `aux_i2c` are due three edges after a pin change: two edges in the synchroniser and one in the output register. The bench drives at falling edges and samples at falling edges, so that count is exact. A port change lands on edge `PAUSE_CYC`+3, the hot-plug low window opens one edge after that, and it closes `SWITCH_CYC` edges later. The directed tests sample on each side of these edges to pin down the timing. The vector table waits well past the longest switch, so it checks only settled levels.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    ST_LINKED = 2'd0,
    ST_SETTLE = 2'd1,
    ST_REPLUG = 2'd2
  } sel_state_t;

  // Port the sense lines ask for; keeps the current one when nothing is plugged.
  function automatic logic pick_b(input logic pa, input logic pb,
                                  input logic favour_b, input logic cur_b);
    if (pa && pb)  return favour_b;
    if (pb)        return 1'b1;
    if (pa)        return 1'b0;
    return cur_b;
  endfunction

endpackage

// File: rtl/hps_sync2.sv
module hps_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hps_select.sv
module hps_select
  import hps_pkg::*;
#(
  parameter int PAUSE_CYC  = 300_000,
  parameter int SWITCH_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic awake,
  input  logic pa,
  input  logic pb,
  input  logic favour_b,
  output logic cur_b,
  output logic replug,
  output logic settling
);
  localparam int CNT_MAX = (PAUSE_CYC > SWITCH_CYC) ? PAUSE_CYC : SWITCH_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] PAUSE_LAST  = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] SWITCH_LAST = CW'(SWITCH_CYC - 1);

  sel_state_t    state;
  logic [CW-1:0] cnt;
  logic          want_b;

  always_comb want_b = pick_b(pa, pb, favour_b, cur_b);

  always_ff @(posedge clk) begin
    if (rst || !awake) begin
      state <= ST_LINKED;
      cnt   <= '0;
      cur_b <= 1'b0;
    end else begin
      case (state)
        ST_LINKED: begin
          cnt <= '0;
          if (want_b != cur_b) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (want_b == cur_b) begin
            state <= ST_LINKED;
            cnt   <= '0;
          end else if (cnt == PAUSE_LAST) begin
            cur_b <= want_b;
            state <= ST_REPLUG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_REPLUG: begin
          if (cnt == SWITCH_LAST) begin
            state <= ST_LINKED;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_LINKED;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign replug   = (state == ST_REPLUG);
  assign settling = (state == ST_SETTLE);
endmodule

// File: rtl/hps_pulse_floor.sv
module hps_pulse_floor #(
  parameter int MIN_PULSE_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic awake,
  input  logic raw,
  output logic q
);
  localparam int HW = $clog2(MIN_PULSE_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(MIN_PULSE_CYC - 1);

  logic [HW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst || !awake) begin
      q    <= 1'b0;
      hold <= '0;
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
    end else if (raw != q) begin
      q    <= raw;
      hold <= HOLD_LAST;
    end
  end
endmodule

// File: rtl/hpd_port_sel.sv
module hpd_port_sel #(
  parameter int PAUSE_CYC     = 300_000,
  parameter int SWITCH_CYC    = 25_000_000,
  parameter int MIN_PULSE_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_n,
  input  logic sense_a,
  input  logic sense_b,
  input  logic adapt_a,
  input  logic adapt_b,
  input  logic prio_b,
  output logic hpd_src,
  output logic cad_src,
  output logic sel_b,
  output logic link_en,
  output logic aux_i2c
);
  localparam int NPIN = 6;

  logic [NPIN-1:0] pins_raw, pins_s;
  logic awake, pa, pb, ca, cb, favour_b;
  logic cur_b, replug, settling, hpd_raw, cad_sel;

  assign pins_raw = {sleep_n, prio_b, adapt_b, adapt_a, sense_b, sense_a};
  assign {awake, favour_b, cb, ca, pb, pa} = pins_s;

  hps_sync2 #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  hps_select #(.PAUSE_CYC(PAUSE_CYC), .SWITCH_CYC(SWITCH_CYC)) u_select (
    .clk(clk), .rst(rst), .awake(awake), .pa(pa), .pb(pb),
    .favour_b(favour_b), .cur_b(cur_b), .replug(replug), .settling(settling)
  );

  assign hpd_raw = !replug && (cur_b ? pb : pa);
  assign cad_sel = cur_b ? cb : ca;

  hps_pulse_floor #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_floor (
    .clk(clk), .rst(rst), .awake(awake), .raw(hpd_raw), .q(hpd_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      link_en <= 1'b0;
      cad_src <= 1'b0;
      aux_i2c <= 1'b0;
    end else begin
      link_en <= awake;
      cad_src <= awake && cad_sel;
      aux_i2c <= awake && cad_sel;
    end
  end

  assign sel_b = cur_b;
endmodule

// File: rtl/hpd_port_sel_chk.sv
module hpd_port_sel_chk (
  input logic clk,
  input logic rst,
  input logic link_en,
  input logic hpd_src,
  input logic cad_src,
  input logic aux_i2c,
  input logic sel_b,
  input logic settling
);
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !link_en |-> (!hpd_src && !cad_src && !aux_i2c)); // R2

  AST_HPD_RISE_HELD: assert property (@(posedge clk) disable iff (rst)
    (link_en && $rose(hpd_src)) |=> (hpd_src || !link_en)); // R8

  AST_HPD_FALL_HELD: assert property (@(posedge clk) disable iff (rst)
    (link_en && $fell(hpd_src)) |=> (!hpd_src || !link_en)); // R8

  AST_AUX_TRACKS_CAD: assert property (@(posedge clk) disable iff (rst)
    aux_i2c == cad_src); // R11

  AST_SEL_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
    (link_en && $past(link_en) && !$stable(sel_b)) |-> $past(settling)); // R6
endmodule

bind hpd_port_sel hpd_port_sel_chk u_chk (
  .clk(clk), .rst(rst), .link_en(link_en), .hpd_src(hpd_src),
  .cad_src(cad_src), .aux_i2c(aux_i2c), .sel_b(sel_b), .settling(settling)
);

// File: tb/hpd_port_sel_bench.sv
module hpd_port_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE  = 20;
  localparam int SWITCH = 50;
  localparam int MINP   = 4;
  localparam int SETTLE = 100;
  localparam int NVEC   = 8;
  // {sense_a, sense_b, adapt_a, adapt_b, prio_b, exp_sel, exp_hpd, exp_cad}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b10000_010, 8'b10100_011, 8'b11010_010, 8'b11011_111,
    8'b00011_101, 8'b10011_010, 8'b01000_110, 8'b11100_011
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_n = 1'b0;
  logic sense_a = 1'b0, sense_b = 1'b0, adapt_a = 1'b0, adapt_b = 1'b0, prio_b = 1'b0;
  logic hpd_src, cad_src, sel_b, link_en, aux_i2c;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_port_sel #(.PAUSE_CYC(PAUSE), .SWITCH_CYC(SWITCH), .MIN_PULSE_CYC(MINP)) u_hpd_port_sel (
    .clk(clk), .rst(rst), .sleep_n(sleep_n), .sense_a(sense_a), .sense_b(sense_b),
    .adapt_a(adapt_a), .adapt_b(adapt_b), .prio_b(prio_b), .hpd_src(hpd_src),
    .cad_src(cad_src), .sel_b(sel_b), .link_en(link_en), .aux_i2c(aux_i2c)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int hi_cnt;
    logic ok;
    tick(3);
    // R1: reset state
    chk("R1", "sel_b", sel_b, 1'b0);
    chk("R1", "link_en", link_en, 1'b0);
    chk("R1", "hpd_src", hpd_src, 1'b0);
    chk("R1", "cad_src", cad_src, 1'b0);
    rst = 1'b0;
    tick(1);
    chk("R1", "link_en after release", link_en, 1'b0);
    sleep_n = 1'b1;
    tick(3);
    chk("R3", "link_en on wake", link_en, 1'b1);

    // Table walk: R4 R5 R9 R10 R11 settled levels
    for (int i = 0; i < NVEC; i++) begin
      {sense_a, sense_b, adapt_a, adapt_b, prio_b} = VEC[i][7:3];
      tick(SETTLE);
      chk("R4/R5", $sformatf("vec%0d sel_b", i), sel_b, VEC[i][2]);
      chk("R9", $sformatf("vec%0d hpd_src", i), hpd_src, VEC[i][1]);
      chk("R10", $sformatf("vec%0d cad_src", i), cad_src, VEC[i][0]);
      chk("R11", $sformatf("vec%0d aux_i2c", i), aux_i2c, VEC[i][0]);
      chk("R3", $sformatf("vec%0d link_en", i), link_en, 1'b1);
    end

    // R6 R7: exact switch timing, A -> B (both plugged, prio flips to B)
    prio_b = 1'b1;
    tick(PAUSE + 2);
    chk("R6", "sel_b before pause ends", sel_b, 1'b0);
    tick(1);
    chk("R6", "sel_b at pause end", sel_b, 1'b1);
    chk("R7", "hpd_src still high", hpd_src, 1'b1);
    tick(1);
    chk("R7", "hpd_src dropped", hpd_src, 1'b0);
    tick(SWITCH - 1);
    chk("R7", "hpd_src low at window end", hpd_src, 1'b0);
    tick(1);
    chk("R7", "hpd_src back high", hpd_src, 1'b1);

    // R6: short condition does not switch
    prio_b = 1'b0;
    tick(PAUSE / 2);
    prio_b = 1'b1;
    ok = 1'b1;
    for (int k = 0; k < PAUSE + SWITCH; k++) begin
      tick(1);
      if (!sel_b || !hpd_src) ok = 1'b0;
    end
    chk("R6", "short glitch kept port B and hpd", ok, 1'b1);

    // R5: nothing plugged keeps selection, hpd low
    sense_a = 1'b0;
    sense_b = 1'b0;
    tick(3 + MINP);
    chk("R5", "sel_b kept", sel_b, 1'b1);
    chk("R5", "hpd_src low", hpd_src, 1'b0);

    // R8: one-cycle pulse stretched to MINP
    tick(10);
    sense_b = 1'b1;
    tick(1);
    sense_b = 1'b0;
    hi_cnt = 0;
    for (int k = 0; k < 30; k++) begin
      tick(1);
      if (hpd_src) hi_cnt++;
    end
    chk("R8", "stretched pulse width ok", (hi_cnt == MINP), 1'b1);
    chk("R5", "sel_b after pulse", sel_b, 1'b1);

    // R2: low power
    sense_b = 1'b1;
    adapt_b = 1'b1;
    tick(10);
    chk("R9", "hpd_src before sleep", hpd_src, 1'b1);
    sleep_n = 1'b0;
    tick(3);
    chk("R2", "link_en", link_en, 1'b0);
    chk("R2", "hpd_src", hpd_src, 1'b0);
    chk("R2", "cad_src", cad_src, 1'b0);
    chk("R2", "aux_i2c", aux_i2c, 1'b0);
    chk("R2", "sel_b", sel_b, 1'b0);
    sense_a = 1'b1;
    adapt_a = 1'b1;
    prio_b  = 1'b0;
    tick(10);
    chk("R2", "inputs ignored hpd", hpd_src, 1'b0);
    chk("R2", "inputs ignored cad", cad_src, 1'b0);

    // R3: wake restarts from port A
    sense_a = 1'b0;
    adapt_a = 1'b0;
    sleep_n = 1'b1;
    tick(2);
    chk("R3", "link_en not yet", link_en, 1'b0);
    tick(1);
    chk("R3", "link_en up", link_en, 1'b1);
    chk("R3", "restart on port A", sel_b, 1'b0);
    tick(PAUSE + SWITCH + 10);
    chk("R3", "selection resumes to B", sel_b, 1'b1);
    chk("R9", "hpd_src after wake", hpd_src, 1'b1);
    chk("R10", "cad_src after wake", cad_src, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule